// File: doc/BRIEF.md
# Buck Gate Drive Mode Logic

This block converts a pulse-width command into the two gate enables of a synchronous buck power stage, one for the high-side switch and one for the low-side rectifier switch. A static mode input picks one of two behaviours. In synchronous mode the pulse-width input alone steers both gates as a complementary pair. A rectifier-enable input decides whether the low side conducts while the command is low. Before either gate turns on, the block waits for the other gate to be confirmed off.

In independent mode the pulse-width input and the rectifier-enable input drive the high-side and low-side gates directly, with no interlock. In both modes a global inhibit (undervoltage, thermal or reset) drops both gates at once. A high-side kill from the fault supervisor drops the high side and keeps it off for the rest of the switching period. The minimum turn-on delays are set in clock cycles per side. A fixed timeout stops a dead feedback line from halting the stage.

Top module: `buck_gate_ctl`

## Requirements
- R1: After reset both gates are low, and they stay low in either mode until the first rising edge of the synchronized pulse-width command.
- R2: The pulse-width and rectifier-enable inputs pass through two flip-flops before use, so a gate responds no earlier than the third rising clock edge after an input change.
- R3: In synchronous mode the high-side gate follows the command being high and the low-side gate follows the command being low; a gate turns off on the first clock edge after its phase ends.
- R4: In synchronous mode the two gates are never high in the same cycle.
- R5: In synchronous mode a gate turns on only once the other gate is low, its feedback input reads 0 (gate confirmed off), and at least the programmed minimum delay (0 to 255 cycles) has passed since that side started waiting.
- R6: If the opposite feedback still reads 1, a waiting gate turns on anyway once its wait counter reaches 1023 cycles.
- R7: In synchronous mode, with rectifier-enable at 0, the low-side gate stays low through the command-low phase.
- R8: In independent mode the high-side gate follows the synchronized command and the low-side gate follows the synchronized rectifier-enable, and both may be high together.
- R9: While inhibit is 1, both gates are low in that same cycle, in either mode.
- R10: A high-side kill drops the high-side gate in the same cycle. The high side then stays low until the next rising edge of the command, even after the kill input returns to 0. The kill has no effect on the low side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| indep_mode | input | 1 | 1 = independent mode, 0 = synchronous mode (static) |
| pwm_in | input | 1 | Asynchronous pulse-width command |
| rect_en_in | input | 1 | Asynchronous rectifier enable / low-side command |
| inhibit | input | 1 | Global inhibit, forces both gates low |
| hs_kill | input | 1 | High-side kill from the fault supervisor |
| hs_fb | input | 1 | 1 while the high-side gate is sensed high |
| ls_fb | input | 1 | 1 while the low-side gate is sensed high |
| hs_min_dly | input | 8 | Minimum wait in cycles before high-side turn-on |
| ls_min_dly | input | 8 | Minimum wait in cycles before low-side turn-on |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
A wrong wait count or a missed feedback condition shifts a gate's turn-on edge by at least one cycle. It therefore shows up in the same switching period as a gate edge the reference misses. A kill latch or arming flag held in the wrong state leaves the high side low, or high, for a whole command period, so the mismatch lasts many cycles. A broken interlock shows as both gates high in a single cycle. The timeout path only shows after the 1023-cycle wait with feedback stuck high, so that case gets its own long command-high phase.

// File: rtl/gdl_pkg.sv
// Shared constants for the buck gate drive logic.
// Assumes the wait counter is at least as wide as the delay fields.
package gdl_pkg;
    localparam int unsigned DLY_W      = 8;
    localparam int unsigned TMO_CYCLES = 1023;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/gdl_sync.sv
// Multi-flop synchronizer for one asynchronous level input.
// Assumes STAGES >= 2; output resets low.
module gdl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // one stage of the resynchronizing chain
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gdl_arm_kill.sv
// Tracks the command rising edge, the post-reset arming flag and the
// held high-side kill. Assumes cmd_s is already synchronized.
module gdl_arm_kill (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    input  logic kill_in,
    output logic cmd_rise,
    output logic arm_ok,
    output logic kill_ok
);
    logic cmd_prev_q;
    logic armed_q;
    logic kill_q;

    assign cmd_rise = cmd_s & ~cmd_prev_q;
    assign arm_ok   = armed_q | cmd_rise;
    assign kill_ok  = ~kill_in & (~kill_q | cmd_rise);

    // edge detector history, arming flag and kill latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_prev_q <= 1'b0;
            armed_q    <= 1'b0;
            kill_q     <= 1'b0;
        end else begin
            cmd_prev_q <= cmd_s;
            armed_q    <= armed_q | cmd_rise;
            if (kill_in)       kill_q <= 1'b1;
            else if (cmd_rise) kill_q <= 1'b0;
        end
    end

    AST_KILL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        kill_in |=> !kill_ok || cmd_rise); // R10
endmodule

// File: rtl/gdl_deadtime.sv
// One side of the adaptive dead-time interlock. The gate turns on when it
// is wanted, the opposite gate is off, and either (feedback low and the
// minimum delay elapsed) or the timeout count is reached. Turn-off is
// immediate. Assumes CNT_W >= DLY_W.
module gdl_deadtime #(
    parameter int unsigned DLY_W      = 8,
    parameter int unsigned TMO_CYCLES = 1023,
    localparam int unsigned CNT_W     = $clog2(TMO_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             want,
    input  logic             opp_on,
    input  logic             opp_fb,
    input  logic [DLY_W-1:0] min_dly,
    output logic             gate_q
);
    localparam logic [CNT_W-1:0] TMO = CNT_W'(TMO_CYCLES);

    logic [CNT_W-1:0] wait_cnt;
    logic             tmo_hit;
    logic             fb_ok;
    logic             may_on;

    assign tmo_hit = (wait_cnt == TMO);
    assign fb_ok   = ~opp_fb & (wait_cnt >= CNT_W'(min_dly));
    assign may_on  = ~opp_on & (fb_ok | tmo_hit);

    // gate state: drop at once, rise only through the interlock
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !want) gate_q <= 1'b0;
        else if (!gate_q)           gate_q <= may_on;
    end

    // wait counter: cycles spent wanting the gate while it is off
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !want || gate_q) wait_cnt <= '0;
        else if (!tmo_hit)                    wait_cnt <= wait_cnt + 1'b1;
    end

    AST_ON_AFTER_OPP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> $past(!opp_on)); // R5
    AST_TIMEOUT_FORCES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_hit && want && !gate_q && !opp_on && !clr) |=> gate_q); // R6
endmodule

// File: rtl/buck_gate_ctl.sv
// Top level of the buck gate drive mode logic: synchronizes the commands,
// selects synchronous (interlocked) or independent (pass-through) drive,
// and applies inhibit and high-side kill at the outputs.
// Assumes indep_mode is static during operation.
module buck_gate_ctl
    import gdl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             indep_mode,
    input  logic             pwm_in,
    input  logic             rect_en_in,
    input  logic             inhibit,
    input  logic             hs_kill,
    input  logic             hs_fb,
    input  logic             ls_fb,
    input  logic [DLY_W-1:0] hs_min_dly,
    input  logic [DLY_W-1:0] ls_min_dly,
    output logic             hs_gate,
    output logic             ls_gate
);
    logic pwm_s, rect_s;
    logic cmd_rise, arm_ok, kill_ok;
    logic want_hs, want_ls, dt_clr;
    logic dt_hs_q, dt_ls_q;
    logic ind_hs_q, ind_ls_q;
    logic hs_sel, ls_sel;

    gdl_sync #(.STAGES(SYNC_STAGES)) u_sync_pwm (
        .clk(clk), .rst_n(rst_n), .d_async(pwm_in), .q_sync(pwm_s));
    gdl_sync #(.STAGES(SYNC_STAGES)) u_sync_rect (
        .clk(clk), .rst_n(rst_n), .d_async(rect_en_in), .q_sync(rect_s));

    gdl_arm_kill u_arm (
        .clk(clk), .rst_n(rst_n), .cmd_s(pwm_s), .kill_in(hs_kill),
        .cmd_rise(cmd_rise), .arm_ok(arm_ok), .kill_ok(kill_ok));

    assign want_hs = arm_ok & pwm_s & kill_ok;
    assign want_ls = arm_ok & ~pwm_s & rect_s;
    assign dt_clr  = inhibit | indep_mode;

    gdl_deadtime #(.DLY_W(DLY_W), .TMO_CYCLES(TMO_CYCLES)) u_dt_hs (
        .clk(clk), .rst_n(rst_n), .clr(dt_clr), .want(want_hs),
        .opp_on(dt_ls_q), .opp_fb(ls_fb), .min_dly(hs_min_dly), .gate_q(dt_hs_q));
    gdl_deadtime #(.DLY_W(DLY_W), .TMO_CYCLES(TMO_CYCLES)) u_dt_ls (
        .clk(clk), .rst_n(rst_n), .clr(dt_clr), .want(want_ls),
        .opp_on(dt_hs_q), .opp_fb(hs_fb), .min_dly(ls_min_dly), .gate_q(dt_ls_q));

    // independent-mode pass-through registers
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit) begin
            ind_hs_q <= 1'b0;
            ind_ls_q <= 1'b0;
        end else begin
            ind_hs_q <= arm_ok & pwm_s & kill_ok;
            ind_ls_q <= arm_ok & rect_s;
        end
    end

    assign hs_sel  = indep_mode ? ind_hs_q : dt_hs_q;
    assign ls_sel  = indep_mode ? ind_ls_q : dt_ls_q;
    assign hs_gate = hs_sel & ~inhibit & ~hs_kill;
    assign ls_gate = ls_sel & ~inhibit;

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !indep_mode |-> !(hs_gate && ls_gate)); // R4
    AST_UNARMED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !u_arm.armed_q |-> !hs_sel && !ls_sel); // R1
    AST_KILL_NEXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hs_kill |=> !hs_sel); // R10
    AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !dt_hs_q && !dt_ls_q && !ind_hs_q && !ind_ls_q); // R9
endmodule

// File: tb/sim_buck_gate_ctl.sv
module sim_buck_gate_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic indep_mode = 1'b0, pwm_in = 1'b0, rect_en_in = 1'b0;
    logic inhibit = 1'b0, hs_kill = 1'b0;
    logic hs_fb, ls_fb;
    logic [7:0] hs_min_dly = 8'd0, ls_min_dly = 8'd0;
    logic hs_gate, ls_gate;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string phase = "R1";
    int fb_lag = 0;
    bit stuck_hs = 0, stuck_ls = 0;
    bit [7:0] hs_pipe = '0, ls_pipe = '0;

    // reference model state
    bit p1, p2, s1, s2, pprev, armed, killq, hq, lq, ih, il;
    int ch, cl;

    always #5 clk = ~clk;

    buck_gate_ctl u0 (
        .clk(clk), .rst_n(rst_n), .indep_mode(indep_mode), .pwm_in(pwm_in),
        .rect_en_in(rect_en_in), .inhibit(inhibit), .hs_kill(hs_kill),
        .hs_fb(hs_fb), .ls_fb(ls_fb), .hs_min_dly(hs_min_dly),
        .ls_min_dly(ls_min_dly), .hs_gate(hs_gate), .ls_gate(ls_gate));

    assign hs_fb = stuck_hs | hs_pipe[fb_lag];
    assign ls_fb = stuck_ls | ls_pipe[fb_lag];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // behavioural reference: advance one clock of the rules in the brief
    always @(posedge clk) begin
        bit rise, ok, kok, wh, wl, clr, nh, nl;
        int nch, ncl;
        cyc++;
        if (!rst_n) begin
            p1 = 0; p2 = 0; s1 = 0; s2 = 0; pprev = 0; armed = 0; killq = 0;
            hq = 0; lq = 0; ih = 0; il = 0; ch = 0; cl = 0;
        end else begin
            rise = p2 && !pprev;
            ok   = armed || rise;
            kok  = !hs_kill && (!killq || rise);
            wh   = ok && p2 && kok;
            wl   = ok && !p2 && s2;
            clr  = inhibit || indep_mode;
            nh = 0; nl = 0;
            if (!clr && wh) nh = hq || (!lq && ((ch >= hs_min_dly && !ls_fb) || ch == 1023));
            if (!clr && wl) nl = lq || (!hq && ((cl >= ls_min_dly && !hs_fb) || cl == 1023));
            nch = (clr || !wh || hq) ? 0 : (ch == 1023 ? 1023 : ch + 1);
            ncl = (clr || !wl || lq) ? 0 : (cl == 1023 ? 1023 : cl + 1);
            ih = !inhibit && wh;
            il = !inhibit && ok && s2;
            hq = nh; lq = nl; ch = nch; cl = ncl;
            if (hs_kill) killq = 1; else if (rise) killq = 0;
            armed = ok; pprev = p2;
            p2 = p1; p1 = pwm_in; s2 = s1; s1 = rect_en_in;
        end
    end

    // compare every cycle away from the edge, then advance the feedback lag
    always @(negedge clk) begin
        bit eh, el;
        if (rst_n) begin
            eh = (indep_mode ? ih : hq) && !inhibit && !hs_kill;
            el = (indep_mode ? il : lq) && !inhibit;
            chk(hs_gate == eh, {phase, " hs_gate"}, hs_gate, eh);
            chk(ls_gate == el, {phase, " ls_gate"}, ls_gate, el);
            if (!indep_mode) chk(!(hs_gate && ls_gate), "R4 overlap", hs_gate & ls_gate, 0);
        end
        hs_pipe = {hs_pipe[6:0], hs_gate};
        ls_pipe = {ls_pipe[6:0], ls_gate};
    end

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse(input int hi, input int lo);
        pwm_in = 1; hold(hi);
        pwm_in = 0; hold(lo);
    endtask

    initial begin
        hold(4);
        chk(hs_gate == 0 && ls_gate == 0, "R1 reset", {hs_gate, ls_gate}, 0);
        rst_n = 1; rect_en_in = 1; hold(12);
        chk(ls_gate == 0, "R1 unarmed low side", ls_gate, 0);

        phase = "R3/R5 lag2"; hs_min_dly = 3; ls_min_dly = 5; fb_lag = 2;
        pwm_in = 1; hold(2);
        chk(hs_gate == 0, "R2 sync latency", hs_gate, 0);
        hold(20); pwm_in = 0; hold(20);
        repeat (4) pulse(20, 20);

        phase = "R7"; rect_en_in = 0;
        repeat (2) pulse(15, 15);
        chk(ls_gate == 0, "R7 rectifier off", ls_gate, 0);
        rect_en_in = 1;

        phase = "R4 fast"; hs_min_dly = 0; ls_min_dly = 0; fb_lag = 0;
        repeat (3) pulse(6, 6);
        repeat (5) pulse(1, 1);
        repeat (3) pulse(2, 3);

        phase = "R5 max"; hs_min_dly = 255; ls_min_dly = 255; fb_lag = 3;
        pulse(300, 300);
        hs_min_dly = 3; ls_min_dly = 3;

        phase = "R6";
        stuck_ls = 1; pwm_in = 1; hold(1100);
        chk(hs_gate == 1, "R6 timeout turn-on", hs_gate, 1);
        pwm_in = 0; hold(10); stuck_ls = 0; hold(20);

        phase = "R10"; pwm_in = 1; hold(30);
        hs_kill = 1; #1;
        chk(hs_gate == 0, "R10 immediate kill", hs_gate, 0);
        hold(3); hs_kill = 0; hold(20);
        chk(hs_gate == 0, "R10 kill held", hs_gate, 0);
        pwm_in = 0; hold(20);
        chk(ls_gate == 1, "R10 low side unaffected", ls_gate, 1);
        pwm_in = 1; hold(20);
        chk(hs_gate == 1, "R10 cleared at rise", hs_gate, 1);

        phase = "R9"; inhibit = 1; #1;
        chk(hs_gate == 0 && ls_gate == 0, "R9 inhibit", {hs_gate, ls_gate}, 0);
        hold(5); inhibit = 0; hold(10); pwm_in = 0; hold(20);
        inhibit = 1; #1;
        chk(ls_gate == 0, "R9 inhibit low side", ls_gate, 0);
        hold(3); inhibit = 0; hold(10);

        phase = "R8"; indep_mode = 1; pwm_in = 1; rect_en_in = 1; hold(10);
        chk(hs_gate == 1 && ls_gate == 1, "R8 both on", {hs_gate, ls_gate}, 3);
        pwm_in = 0; hold(10);
        chk(hs_gate == 0 && ls_gate == 1, "R8 low only", {hs_gate, ls_gate}, 1);
        rect_en_in = 0; pwm_in = 1; hold(10);
        chk(hs_gate == 1 && ls_gate == 0, "R8 high only", {hs_gate, ls_gate}, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog cyc=%0d actual=%0d expected=%0d", cyc, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule